// File: doc/BRIEF.md
# Cycle-Dependent Memory Page Mapper

This block widens a 16-bit processor address into an 18-bit physical address for an 8-bit microprocessor system. The two added upper bits come from one of three 2-bit page fields held in an 8-bit mapping register. Which field is used depends on the kind of bus cycle in progress: an opcode fetch, an ordinary memory read, or a memory write. Code can therefore run from one bank while data is read from a second bank and stored into a third.

Software loads the mapping register with an I/O write to a fixed port and can read it back from the same port. The top bit of the register is active low and switches on a boot ROM overlay. While the overlay is on, reads from the lowest 8 KiB select the ROM in place of RAM, but writes to that window still reach RAM. Reset clears the register, so every page is bank 0 and the overlay is on, and the processor starts from ROM. The mapping is combinational from the register, so a new value applies from the bus cycle that follows the write.

Top module: `cycle_page_map`

## Requirements
- R1: After reset the register reads back 0x00: all three page fields are bank 0 and the ROM overlay is on.
- R2: An I/O write (ioReqN=0, wrN=0, memReqN=1) whose address bits 7:0 equal 0xFC loads the register from cpuDataIn at the clock edge. I/O writes to other ports and memory writes leave it unchanged.
- R3: An I/O read (ioReqN=0, rdN=0, fetchN=1) at port 0xFC drives the register onto cpuDataOut with bit 6 as 0 and sets cpuDataOe. Otherwise cpuDataOe is 0 and cpuDataOut is 0x00.
- R4: In a memory read that is not a fetch (memReqN=0, rdN=0, fetchN=1), physAddr[17:16] equals register bits 1:0.
- R5: In a memory write (memReqN=0, wrN=0), physAddr[17:16] equals register bits 3:2.
- R6: In an opcode fetch (fetchN=0, memReqN=0, rdN=0), physAddr[17:16] equals register bits 5:4.
- R7: physAddr[15:0] always equals cpuAddr.
- R8: While register bit 7 is 0, a memory read or fetch at an address below 0x2000 sets romSel=1 and ramSel=0. With bit 7 at 1, or at 0x2000 and above, such cycles set ramSel=1 and romSel=0.
- R9: A memory write sets ramSel=1 and romSel=0 at every address, whatever bit 7 holds.
- R10: Register bit 6 has no effect on mapping or selects and is stored as 0.
- R11: A new register value governs the first bus cycle after the write clock edge.
- R12: With memReqN=1, ramSel and romSel are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | Processor address |
| cpuDataIn | input | 8 | Processor write data |
| ioReqN | input | 1 | I/O request, active low |
| memReqN | input | 1 | Memory request, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| fetchN | input | 1 | Opcode fetch strobe, active low |
| cpuDataOut | output | 8 | Register read-back data |
| cpuDataOe | output | 1 | High while read-back data is driven |
| physAddr | output | 18 | Physical memory address |
| ramSel | output | 1 | RAM select, active high |
| romSel | output | 1 | Boot ROM select, active high |

## Verification
A wrong bit in the mapping register shows at the ports in the very next bus cycle of the matching kind: a bad page field puts the wrong bank on physAddr[17:16], and a bad bit 7 moves low reads between ROM and RAM. Because each field only appears in its own cycle kind, the sweep loads every register value and then runs a fetch, a read and a write at addresses inside and outside the ROM window, so a field swapped between cycle kinds or a misdecoded strobe is seen within one cycle. Read-back at the port exposes stored state straight after each write, including the forced-zero bit 6.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

  // Decoded bus-cycle strobes passed from control to datapath.
  typedef struct packed {
    logic regWr;     // I/O write to the mapping port
    logic regRd;     // I/O read of the mapping port
    logic fetchCyc;  // opcode fetch memory read
    logic readCyc;   // ordinary memory read
    logic writeCyc;  // memory write
  } busStrobe_t;

  localparam int PAGE_FIELDS = 3;
  localparam int FLD_READ  = 0;
  localparam int FLD_WRITE = 1;
  localparam int FLD_FETCH = 2;

endpackage

// File: rtl/pgmap_ctrl.sv
module pgmap_ctrl
  import pgmap_pkg::*;
#(
  parameter int          PORT_W    = 8,
  parameter logic [7:0]  PAGE_PORT = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] ioAddr,
  input  logic              ioReqN,
  input  logic              memReqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              fetchN,
  output busStrobe_t        strb
);

  logic portHit;
  logic ioCyc;
  logic memCyc;

  assign portHit = (ioAddr == PAGE_PORT[PORT_W-1:0]);
  assign ioCyc   = !ioReqN && memReqN;
  assign memCyc  = !memReqN && ioReqN;

  always_comb begin
    strb          = '0;
    strb.regWr    = ioCyc && !wrN && portHit;
    strb.regRd    = ioCyc && !rdN && fetchN && portHit;
    strb.fetchCyc = memCyc && !rdN && !fetchN;
    strb.readCyc  = memCyc && !rdN && fetchN;
    strb.writeCyc = memCyc && !wrN && rdN;
  end

  // At most one memory cycle kind at a time.
  AST_ONE_CYCLE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fetchCyc, strb.readCyc, strb.writeCyc})); // R12
  // A register access never coincides with a memory cycle.
  AST_IO_NOT_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (strb.regWr || strb.regRd) |-> !(strb.fetchCyc || strb.readCyc || strb.writeCyc)); // R2

endmodule

// File: rtl/pgmap_dpath.sv
module pgmap_dpath
  import pgmap_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          EXT_W     = 2,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] ROM_LIMIT = 16'h2000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobe_t              strb,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuDataIn,
  output logic [DATA_W-1:0]       cpuDataOut,
  output logic                    cpuDataOe,
  output logic [ADDR_W+EXT_W-1:0] physAddr,
  output logic                    ramSel,
  output logic                    romSel
);

  localparam int SPARE_BIT   = PAGE_FIELDS * EXT_W;
  localparam int OVERLAY_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << SPARE_BIT);

  logic [DATA_W-1:0] pageReg;
  logic [EXT_W-1:0]  pageField [PAGE_FIELDS];
  logic [EXT_W-1:0]  pageSel;
  logic              overlayOn;
  logic              inRomWin;
  logic              anyRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
    end else if (strb.regWr) begin
      pageReg <= cpuDataIn & STORE_MASK;
    end
  end

  for (genvar g = 0; g < PAGE_FIELDS; g++) begin : gField
    assign pageField[g] = pageReg[g*EXT_W +: EXT_W];
  end

  always_comb begin
    if (strb.fetchCyc)      pageSel = pageField[FLD_FETCH];
    else if (strb.writeCyc) pageSel = pageField[FLD_WRITE];
    else                    pageSel = pageField[FLD_READ];
  end

  assign overlayOn = !pageReg[OVERLAY_BIT];
  assign inRomWin  = (cpuAddr < ROM_LIMIT[ADDR_W-1:0]);
  assign anyRead   = strb.readCyc || strb.fetchCyc;

  assign physAddr   = {pageSel, cpuAddr};
  assign romSel     = anyRead && overlayOn && inRomWin;
  assign ramSel     = (anyRead || strb.writeCyc) && !romSel;
  assign cpuDataOe  = strb.regRd;
  assign cpuDataOut = strb.regRd ? pageReg : '0;

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWr |=> pageReg == ($past(cpuDataIn) & STORE_MASK)); // R2
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(pageReg)); // R2
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !pageReg[SPARE_BIT]); // R10
  AST_WRITE_NO_ROM: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeCyc |-> (ramSel && !romSel)); // R9

endmodule

// File: rtl/cycle_page_map.sv
module cycle_page_map
  import pgmap_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          EXT_W     = 2,
  parameter int          DATA_W    = 8,
  parameter int          PORT_W    = 8,
  parameter logic [7:0]  PAGE_PORT = 8'hFC,
  parameter logic [15:0] ROM_LIMIT = 16'h2000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuDataIn,
  input  logic                    ioReqN,
  input  logic                    memReqN,
  input  logic                    rdN,
  input  logic                    wrN,
  input  logic                    fetchN,
  output logic [DATA_W-1:0]       cpuDataOut,
  output logic                    cpuDataOe,
  output logic [ADDR_W+EXT_W-1:0] physAddr,
  output logic                    ramSel,
  output logic                    romSel
);

  busStrobe_t strb;

  pgmap_ctrl #(
    .PORT_W   (PORT_W),
    .PAGE_PORT(PAGE_PORT)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .ioAddr (cpuAddr[PORT_W-1:0]),
    .ioReqN (ioReqN),
    .memReqN(memReqN),
    .rdN    (rdN),
    .wrN    (wrN),
    .fetchN (fetchN),
    .strb   (strb)
  );

  pgmap_dpath #(
    .ADDR_W   (ADDR_W),
    .EXT_W    (EXT_W),
    .DATA_W   (DATA_W),
    .ROM_LIMIT(ROM_LIMIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuDataIn (cpuDataIn),
    .cpuDataOut(cpuDataOut),
    .cpuDataOe (cpuDataOe),
    .physAddr  (physAddr),
    .ramSel    (ramSel),
    .romSel    (romSel)
  );

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[ADDR_W-1:0] == cpuAddr); // R7
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ramSel && romSel)); // R8
  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    memReqN |-> !(ramSel || romSel)); // R12

endmodule

// File: tb/cycle_page_map_tb_top.sv
`timescale 1ns/1ps
module cycle_page_map_tb_top;

  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuDataIn = 0;
  logic        ioReqN = 1, memReqN = 1, rdN = 1, wrN = 1, fetchN = 1;
  logic [7:0]  cpuDataOut;
  logic        cpuDataOe;
  logic [17:0] physAddr;
  logic        ramSel, romSel;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  cycle_page_map dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .ioReqN(ioReqN), .memReqN(memReqN), .rdN(rdN), .wrN(wrN), .fetchN(fetchN),
    .cpuDataOut(cpuDataOut), .cpuDataOe(cpuDataOe), .physAddr(physAddr),
    .ramSel(ramSel), .romSel(romSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ioReqN = 1; memReqN = 1; rdN = 1; wrN = 1; fetchN = 1;
  endtask

  // I/O write held across one rising edge, released at the next falling edge.
  task automatic ioWrite(input logic [15:0] port, input logic [7:0] val);
    @(negedge clk);
    cpuAddr = port; cpuDataIn = val; ioReqN = 0; wrN = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic ioRead(input logic [15:0] port, output logic [7:0] val, output logic oe);
    @(negedge clk);
    cpuAddr = port; ioReqN = 0; rdN = 0;
    #1;
    val = cpuDataOut; oe = cpuDataOe;
    idle();
  endtask

  // kind: 0 read, 1 write, 2 fetch
  task automatic memCycle(input int kind, input logic [15:0] a, input logic [7:0] regVal);
    logic [1:0] expHi;
    logic expRom, expRam;
    @(negedge clk);
    cpuAddr = a; memReqN = 0;
    if (kind == 1) wrN = 0; else rdN = 0;
    if (kind == 2) fetchN = 0;
    #1;
    expHi  = (kind == 0) ? regVal[1:0] : (kind == 1) ? regVal[3:2] : regVal[5:4];
    expRom = (kind != 1) && !regVal[7] && (a < 16'h2000);
    expRam = !expRom;
    if (kind == 0) check("R4 read page", physAddr[17:16], expHi);
    if (kind == 1) check("R5 write page", physAddr[17:16], expHi);
    if (kind == 2) check("R6 fetch page", physAddr[17:16], expHi);
    check("R7 low address", physAddr[15:0], a);
    if (kind == 1) check("R9 write to RAM", {ramSel, romSel}, 2'b10);
    else           check("R8 overlay select", {ramSel, romSel}, {expRam, expRom});
    idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rb;
    logic oe;
    logic [15:0] addrs [5];
    logic [7:0] prev;
    addrs[0] = 16'h0000; addrs[1] = 16'h1FFF; addrs[2] = 16'h2000;
    addrs[3] = 16'hFFFF; addrs[4] = 16'h5A3C;

    repeat (3) @(posedge clk);
    rstN = 1;

    // R1 reset state
    ioRead(16'h00FC, rb, oe);
    check("R1 reset value", rb, 8'h00);
    check("R3 read enable", oe, 1'b1);
    memCycle(2, 16'h0000, 8'h00);  // R1 boots from ROM

    // R12 no memory request
    @(negedge clk); cpuAddr = 16'h0100; rdN = 0; #1;
    check("R12 idle selects", {ramSel, romSel}, 2'b00);
    idle();

    // R3 read at another port
    ioRead(16'h00FD, rb, oe);
    check("R3 other port data", rb, 8'h00);
    check("R3 other port oe", oe, 1'b0);

    // Sweep every register value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] stored;
      stored = v[7:0] & 8'hBF;
      ioWrite(16'h00FC + ((v % 4) << 8), v[7:0]);  // R2 high address bits ignored
      ioRead(16'h00FC, rb, oe);
      check("R2 R10 readback", rb, stored);
      for (int i = 0; i < 5; i++) begin
        for (int k = 0; k < 3; k++) memCycle(k, addrs[i], stored);
      end
    end

    // R10 bit 6 no effect: compare mapping with and without bit 6
    ioWrite(16'h00FC, 8'h79);
    memCycle(0, 16'h0010, 8'h39);
    memCycle(2, 16'h0010, 8'h39);

    // R2 ignored writes
    prev = 8'h39;
    ioWrite(16'h00FD, 8'hFF);
    ioRead(16'h00FC, rb, oe);
    check("R2 other port ignored", rb, prev);
    @(negedge clk); cpuAddr = 16'h00FC; cpuDataIn = 8'hAA; memReqN = 0; wrN = 0;
    @(negedge clk); idle();
    ioRead(16'h00FC, rb, oe);
    check("R2 memory write ignored", rb, prev);

    // R11 next-cycle effect
    @(negedge clk); cpuAddr = 16'h00FC; cpuDataIn = 8'hA4; ioReqN = 0; wrN = 0;
    @(negedge clk); idle(); cpuAddr = 16'h1000; memReqN = 0; rdN = 0; fetchN = 0; #1;
    check("R11 fetch page next cycle", physAddr[17:16], 2'b10);
    check("R11 overlay off next cycle", {ramSel, romSel}, 2'b10);
    idle();

    // R1 reset clears again
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1;
    ioRead(16'h00FC, rb, oe);
    check("R1 reset after use", rb, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule